// File: doc/BRIEF.md
# Scatter-Gather Write DMA (Push Engine)

This block is the write side of a descriptor-driven DMA. It takes a byte stream, for example the output of a cipher core, and scatters it into word-addressed memory. A linked list of descriptors in memory tells it where each part of the stream goes. A host gives the byte address of the first descriptor and pulses a start strobe. The engine then fetches each descriptor and moves the number of stream bytes that descriptor names. It follows the next pointer until a descriptor marks the end of the chain. A busy output stays high for the whole walk.

A descriptor occupies four 32-bit words. The engine reads the first three: the target byte address, the next pointer and a length word that also holds flags. The fourth word is a tag, which only the fetch side uses. A descriptor can ask for its bytes to be dropped. This lets reflected header and padding bytes be thrown away inline, with no memory traffic. A descriptor can also hold its target word address fixed, which suits a FIFO-like sink. Bytes are packed into 32-bit words. Words that are only partly filled are written with byte enables.

Top module: `sg_push_engine`

## Requirements
- R1: During reset and afterwards until a start, `busy`, `inReady`, `memWrEn` and `descRdEn` are all low.
- R2: A descriptor at byte address D is read with 1-cycle-latency reads at D+0 (target byte address), D+4 (next pointer) and D+8 (length word). The byte count is in length-word bits [LEN_W-1:0].
- R3: A next pointer with bit 0 set ends the chain. Otherwise the next descriptor is fetched from the pointer with bits [1:0] cleared.
- R4: When bit 30 of the length word is set, the engine consumes the given number of stream bytes, writes nothing to memory and ignores the target address.
- R5: When bits 30 and 28 of the length word are both clear, stream byte k of the descriptor lands at target address + k.
- R6: When bit 28 is set (and bit 30 is clear), the word address stays fixed at the target's word. Byte k goes to byte lane (target[1:0] + k) mod 4.
- R7: Every memory write is word-aligned and carries byte enables for only the bytes written. Neighbouring bytes of partly filled words keep their old contents.
- R8: `busy` rises in the cycle after an accepted start. It falls only after the last byte of the final descriptor has been taken and written.
- R9: If `inValid` drops in the middle of a descriptor, the engine waits. It consumes exactly the sum of the descriptor lengths and no more.
- R10: A start pulse while `busy` is high is ignored.
- R11: A descriptor with zero length consumes no bytes, and the walk goes on to its next pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle strobe that starts a chain walk |
| firstDesc | input | 32 | Byte address of the first descriptor |
| busy | output | 1 | High while a chain is being walked |
| descRdEn | output | 1 | Descriptor word read request |
| descRdAddr | output | 32 | Byte address of the descriptor word being read |
| descRdData | input | 32 | Read data, valid one cycle after `descRdEn` |
| inValid | input | 1 | Stream byte available |
| inReady | output | 1 | Engine accepts a stream byte this cycle |
| inByte | input | 8 | Stream byte |
| memWrEn | output | 1 | Memory word write strobe |
| memWrAddr | output | 32 | Word-aligned byte address of the write |
| memWrData | output | 32 | Write data, lane n in bits [8n+7:8n] |
| memWrBe | output | 4 | Byte enables for the write |

## Verification
The assertions assume that memory accepts every write and every descriptor read with no back-pressure, and that read data returns exactly one cycle after `descRdEn`. The bench memory model returns data on that fixed latency and never stalls. The assertions also assume that `inValid` and `inByte` change only between clock edges. The stream source drives them on the falling edge and holds a byte until it has been taken. Descriptors and target buffers are kept in separate regions, so no write of the engine can alter a descriptor it has yet to fetch.

// File: rtl/sg_push_pkg.sv
package sg_push_pkg;
  localparam int WORD_W     = 32;
  localparam int LANES      = WORD_W / 8;
  localparam int LANE_W     = $clog2(LANES);
  localparam int DROP_BIT   = 30;
  localparam int FIXED_BIT  = 28;
  localparam int STOP_BIT   = 0;
  localparam int IDX_W      = 2;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RDREQ, ST_RDCAP, ST_MOVE, ST_LINK
  } pushState_t;

  typedef struct packed {
    logic             setFirst;
    logic             setLinked;
    logic             capture;
    logic [IDX_W-1:0] wordIdx;
    logic             takeByte;
  } pushStrobes_t;
endpackage

// File: rtl/sg_push_ctrl.sv
module sg_push_ctrl
  import sg_push_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic         inValid,
  input  logic         remZero,
  input  logic         remOne,
  input  logic         chainStop,
  output pushStrobes_t strobes,
  output logic         descRdEn,
  output logic         inReady,
  output logic         busy
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(2);

  pushState_t       state, stateNext;
  logic [IDX_W-1:0] idx, idxNext;

  always_comb begin
    strobes           = '0;
    strobes.wordIdx   = idx;
    descRdEn          = (state == ST_RDREQ);
    inReady           = (state == ST_MOVE) && !remZero;
    strobes.takeByte  = inReady && inValid;
    strobes.capture   = (state == ST_RDCAP);
    strobes.setFirst  = (state == ST_IDLE) && start;
    strobes.setLinked = (state == ST_LINK) && !chainStop;
    busy              = (state != ST_IDLE);
  end

  always_comb begin
    stateNext = state;
    idxNext   = idx;
    unique case (state)
      ST_IDLE: if (start) begin
        stateNext = ST_RDREQ;
        idxNext   = '0;
      end
      ST_RDREQ: stateNext = ST_RDCAP;
      ST_RDCAP: begin
        if (idx == LAST_IDX) stateNext = ST_MOVE;
        else begin
          idxNext   = idx + 1'b1;
          stateNext = ST_RDREQ;
        end
      end
      ST_MOVE: begin
        if (remZero) stateNext = ST_LINK;
        else if (strobes.takeByte && remOne) stateNext = ST_LINK;
      end
      ST_LINK: begin
        idxNext   = '0;
        stateNext = chainStop ? ST_IDLE : ST_RDREQ;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      idx   <= '0;
    end else begin
      state <= stateNext;
      idx   <= idxNext;
    end
  end
endmodule

// File: rtl/sg_push_dpath.sv
module sg_push_dpath
  import sg_push_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  pushStrobes_t      strobes,
  input  logic [WORD_W-1:0] firstDesc,
  input  logic [WORD_W-1:0] descRdData,
  input  logic [7:0]        inByte,
  output logic [WORD_W-1:0] descRdAddr,
  output logic              memWrEn,
  output logic [WORD_W-1:0] memWrAddr,
  output logic [WORD_W-1:0] memWrData,
  output logic [LANES-1:0]  memWrBe,
  output logic              remZero,
  output logic              remOne,
  output logic              chainStop
);
  logic [WORD_W-1:0] descBase, curAddr, nextPtr, packData, mergedData;
  logic [LANES-1:0]  packBe, mergedBe;
  logic [LEN_W-1:0]  remLen;
  logic              dropF, fixedF, flush;
  logic [LANE_W-1:0] lane;

  wire unusedBits = ^{descRdData[WORD_W-1], descRdData[DROP_BIT-1],
                      descRdData[FIXED_BIT-1:LEN_W]};

  assign descRdAddr = descBase + {{(WORD_W-IDX_W-2){1'b0}}, strobes.wordIdx, 2'b00};
  assign remZero    = (remLen == '0);
  assign remOne     = (remLen == LEN_W'(1));
  assign chainStop  = nextPtr[STOP_BIT];
  assign lane       = curAddr[LANE_W-1:0];

  always_comb begin
    mergedData              = packData;
    mergedData[lane*8 +: 8] = inByte;
    mergedBe                = packBe | (LANES'(1) << lane);
    flush                   = (lane == {LANE_W{1'b1}}) || remOne;
  end

  assign memWrEn   = strobes.takeByte && !dropF && flush;
  assign memWrAddr = {curAddr[WORD_W-1:LANE_W], {LANE_W{1'b0}}};
  assign memWrData = mergedData;
  assign memWrBe   = mergedBe;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      descBase <= '0;
      curAddr  <= '0;
      nextPtr  <= '0;
      remLen   <= '0;
      dropF    <= 1'b0;
      fixedF   <= 1'b0;
      packData <= '0;
      packBe   <= '0;
    end else begin
      if (strobes.setFirst) descBase <= firstDesc;
      else if (strobes.setLinked) descBase <= {nextPtr[WORD_W-1:2], 2'b00};

      if (strobes.capture) begin
        case (strobes.wordIdx)
          IDX_W'(0): curAddr <= descRdData;
          IDX_W'(1): nextPtr <= descRdData;
          IDX_W'(2): begin
            remLen   <= descRdData[LEN_W-1:0];
            dropF    <= descRdData[DROP_BIT];
            fixedF   <= descRdData[FIXED_BIT];
            packData <= '0;
            packBe   <= '0;
          end
          default: ;
        endcase
      end

      if (strobes.takeByte) begin
        remLen <= remLen - 1'b1;
        if (!dropF) begin
          if (flush) begin
            packData <= '0;
            packBe   <= '0;
          end else begin
            packData <= mergedData;
            packBe   <= mergedBe;
          end
          if (fixedF) curAddr[LANE_W-1:0] <= lane + 1'b1;
          else        curAddr <= curAddr + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sg_push_engine.sv
module sg_push_engine
  import sg_push_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic [31:0] firstDesc,
  output logic        busy,
  output logic        descRdEn,
  output logic [31:0] descRdAddr,
  input  logic [31:0] descRdData,
  input  logic        inValid,
  output logic        inReady,
  input  logic [7:0]  inByte,
  output logic        memWrEn,
  output logic [31:0] memWrAddr,
  output logic [31:0] memWrData,
  output logic [3:0]  memWrBe
);
  pushStrobes_t strobes;
  logic remZero, remOne, chainStop;

  sg_push_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .inValid(inValid),
    .remZero(remZero), .remOne(remOne), .chainStop(chainStop),
    .strobes(strobes), .descRdEn(descRdEn), .inReady(inReady), .busy(busy)
  );

  sg_push_dpath #(.LEN_W(LEN_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .firstDesc(firstDesc),
    .descRdData(descRdData), .inByte(inByte), .descRdAddr(descRdAddr),
    .memWrEn(memWrEn), .memWrAddr(memWrAddr), .memWrData(memWrData),
    .memWrBe(memWrBe), .remZero(remZero), .remOne(remOne), .chainStop(chainStop)
  );
endmodule

// File: rtl/sg_push_checks.sv
module sg_push_checks (
  input logic        clk,
  input logic        rstN,
  input logic        start,
  input logic        busy,
  input logic        descRdEn,
  input logic [31:0] descRdAddr,
  input logic        inValid,
  input logic        inReady,
  input logic        memWrEn,
  input logic [31:0] memWrAddr,
  input logic [3:0]  memWrBe
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!inReady && !memWrEn && !descRdEn));

  p_desc_aligned_r2: assert property (@(posedge clk) disable iff (!rstN)
    descRdEn |-> (descRdAddr[1:0] == 2'b00));

  p_wr_aligned_r7: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> (memWrAddr[1:0] == 2'b00 && memWrBe != 4'b0000));

  p_wr_needs_byte_r9: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> (inValid && inReady));

  p_busy_rise_r8: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);

  p_no_read_while_moving_r2: assert property (@(posedge clk) disable iff (!rstN)
    inReady |-> !descRdEn);
endmodule

bind sg_push_engine sg_push_checks u_chk (.*);

// File: tb/sg_push_engine_test.sv
module sg_push_engine_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [31:0] firstDesc = '0;
  logic        busy, descRdEn, inReady, memWrEn;
  logic [31:0] descRdAddr, memWrAddr, memWrData;
  logic [31:0] descRdData = '0;
  logic [3:0]  memWrBe;
  logic        inValid = 1'b0;
  logic [7:0]  inByte = '0;

  sg_push_engine uut (
    .clk(clk), .rstN(rstN), .start(start), .firstDesc(firstDesc), .busy(busy),
    .descRdEn(descRdEn), .descRdAddr(descRdAddr), .descRdData(descRdData),
    .inValid(inValid), .inReady(inReady), .inByte(inByte),
    .memWrEn(memWrEn), .memWrAddr(memWrAddr), .memWrData(memWrData), .memWrBe(memWrBe)
  );

  always #2 clk = ~clk;

  // vector: [31:16] target, [15:8] length, [1] fixed word, [0] drop
  localparam logic [31:0] VEC [0:7] = '{
    32'h0000_1000, 32'h0013_0700, 32'h0041_0300, 32'h0080_0902,
    32'h0092_0602, 32'h00A0_0C01, 32'h0101_0100, 32'h0120_2800
  };
  localparam int DESC0 = 32'h280;

  logic [31:0] mem [0:255];
  logic [7:0]  expB [0:1023];
  logic [7:0]  strm [0:255];
  int strmLen = 0, feedPtr = 0, modelPtr = 0, cyc = 0;
  bit stallOn = 0, lastTake = 0, resetFeed = 0;
  int nChecks = 0, nFails = 0;

  always @(posedge clk) begin
    if (descRdEn) descRdData <= mem[descRdAddr[9:2]];
    if (memWrEn)
      for (int l = 0; l < 4; l++)
        if (memWrBe[l]) mem[memWrAddr[9:2]][l*8 +: 8] <= memWrData[l*8 +: 8];
  end

  always @(negedge clk) begin
    cyc++;
    if (resetFeed) begin
      feedPtr = 0; lastTake = 0; resetFeed = 0;
    end else if (lastTake) feedPtr++;
    inValid = (feedPtr < strmLen) && !(stallOn && (cyc % 3 == 0));
    inByte  = strm[feedPtr & 255];
    lastTake = inValid && inReady;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic initMem(input int seed, input int len);
    for (int i = 0; i < 256; i++) begin
      mem[i] = 32'h5A5A_0000 | i;
      for (int l = 0; l < 4; l++) expB[i*4+l] = mem[i][l*8 +: 8];
    end
    for (int k = 0; k < 256; k++) strm[k] = 8'(k*7 + seed + 1);
    strmLen = len; modelPtr = 0;
    resetFeed = 1;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic setDesc(input int ba, input logic [31:0] tgt, input logic [31:0] nxt,
                         input int len, input bit drop, input bit fixd);
    mem[ba/4]   = tgt;
    mem[ba/4+1] = nxt;
    mem[ba/4+2] = 32'(len) | (32'(drop) << 30) | (32'(fixd) << 28);
    mem[ba/4+3] = 32'h0;
  endtask

  task automatic modelDesc(input logic [31:0] tgt, input int len, input bit drop, input bit fixd);
    for (int k = 0; k < len; k++) begin
      logic [31:0] a;
      a = fixd ? {tgt[31:2], 2'(tgt[1:0] + 2'(k))} : tgt + 32'(k);
      if (!drop) expB[a[9:0]] = strm[modelPtr];
      modelPtr++;
    end
  endtask

  task automatic compareMem(input string req);
    int mis = 0; logic [7:0] fa = 0, fe = 0;
    for (int b = 0; b < DESC0; b++)
      if (mem[b/4][(b%4)*8 +: 8] !== expB[b]) begin
        if (mis == 0) begin fa = mem[b/4][(b%4)*8 +: 8]; fe = expB[b]; end
        mis++;
      end
    check(mis == 0, req, "memory bytes", fa, fe);
  endtask

  task automatic runChain(input logic [31:0] first, input int expCount, input string req);
    @(negedge clk); firstDesc = first; start = 1;
    @(negedge clk); start = 0;
    check(busy == 1'b1, "R8", "busy after start", busy, 1);
    while (busy) @(negedge clk);
    check(feedPtr == expCount, "R8", "bytes taken when busy fell", feedPtr, expCount);
    repeat (3) @(negedge clk);
    check(feedPtr == expCount, req, "bytes consumed", feedPtr, expCount);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    for (int k = 0; k < 256; k++) strm[k] = 0;
    repeat (4) @(negedge clk);
    check(busy == 0 && inReady == 0, "R1", "busy/inReady in reset", {busy, inReady}, 0);
    rstN = 1;
    repeat (2) @(negedge clk);
    check(busy == 0, "R1", "busy after reset", busy, 0);
    check(memWrEn == 0 && descRdEn == 0 && inReady == 0, "R1", "idle strobes",
          {memWrEn, descRdEn, inReady}, 0);

    // table walk: one descriptor each (R2 R4 R5 R6 R7 R9)
    for (int v = 0; v < 8; v++) begin
      logic [31:0] t; int n; bit dr, fx; string req;
      t = {16'h0, VEC[v][31:16]}; n = int'(VEC[v][15:8]);
      dr = VEC[v][0]; fx = VEC[v][1];
      req = dr ? "R4" : (fx ? "R6" : ((t[1:0] != 0 || n % 4 != 0) ? "R7" : "R5"));
      stallOn = v[0];
      initMem(v, n);
      setDesc(DESC0, t, 32'h1, n, dr, fx);
      modelDesc(t, n, dr, fx);
      runChain(DESC0, n, stallOn ? "R9" : "R2");
      compareMem(req);
    end

    // chain with masked-low-bits link, drop, zero length, fixed (R3 R4 R11 R6)
    stallOn = 1;
    initMem(40, 14);
    setDesc(DESC0,        32'h10, 32'h292, 5, 0, 0);
    setDesc(DESC0 + 16,   32'h10, 32'h2A0, 6, 1, 0);
    setDesc(DESC0 + 32,   32'h30, 32'h2B0, 0, 0, 0);
    setDesc(DESC0 + 48,   32'h41, 32'h001, 3, 0, 1);
    modelDesc(32'h10, 5, 0, 0);
    modelDesc(32'h10, 6, 1, 0);
    modelDesc(32'h41, 3, 0, 1);
    runChain(DESC0, 14, "R11");
    compareMem("R3");

    // start while busy is ignored (R10)
    stallOn = 1;
    initMem(77, 48);
    setDesc(DESC0, 32'h20, 32'h1, 40, 0, 0);
    setDesc(DESC0 + 64, 32'h180, 32'h1, 4, 0, 0);
    modelDesc(32'h20, 40, 0, 0);
    @(negedge clk); firstDesc = DESC0; start = 1;
    @(negedge clk); start = 0;
    repeat (20) @(negedge clk);
    firstDesc = DESC0 + 64; start = 1;
    @(negedge clk); start = 0;
    while (busy) @(negedge clk);
    repeat (10) @(negedge clk);
    check(feedPtr == 40, "R10", "bytes consumed", feedPtr, 40);
    check(busy == 0, "R10", "no second walk", busy, 0);
    compareMem("R10");

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule